// File: doc/BRIEF.md
# Program Interrupt Entry Unit

This block sits at the retire point of an in-order core and decides, for each executed instruction, whether that instruction must divert into the program interrupt handler instead of completing normally. It receives the address of the instruction being executed, the current machine state register (MSR), and two decoded flags: one says the operation needs supervisor rights, the other says the encoding is not a legal instruction. Decoding itself happens upstream.

On an execute request with no fault, the block registers the sequential next address (current plus 4) and passes the MSR through unchanged. When a fault is detected, it does the following on the same clock edge:
- saves the faulting address in the saved-PC register;
- saves the old MSR, with one cause bit added, in the saved-MSR register;
- forces a fixed pattern of MSR bits into the outgoing MSR;
- redirects the next address to the program interrupt vector;
- pulses a one-cycle trap strobe.

Top module: `pgm_int_entry`

## Requirements
- R1: While reset (rstN low) is asserted and after its release, nextPc, msrOut, srr0, srr1 are all zero and trapTaken is 0 until the first execute.
- R2: In a cycle with execReq low, nextPc, msrOut, srr0 and srr1 keep their values, and trapTaken is 0 on the following cycle.
- R3: An execute without a fault sets nextPc = curPc + 4 and msrOut = msrIn, leaves srr0 and srr1 unchanged, and keeps trapTaken at 0.
- R4: An execute with privOp high while the problem-state bit msrIn[14] is 1 takes a trap whose cause is privileged, marked by bit 18 of srr1.
- R5: An execute with privOp high while msrIn[14] is 0, and illegalOp low, completes normally as in R3.
- R6: An execute with illegalOp high takes a trap whose cause is illegal instruction, marked by bit 19 of srr1.
- R7: When both causes apply, only the privileged cause is recorded: srr1 bit 18 is set and bit 19 is taken from the old MSR.
- R8: On a trap, srr0 = curPc, srr1 = msrIn with the single cause bit ORed in, and nextPc = 0x700; the cause bit does not appear in msrOut unless msrIn already carried it.
- R9: On a trap, msrOut = msrIn with bits 0 and 63 set and bits 1, 2, 4, 5, 8, 11, 13, 14, 15, 23, 25, 32, 33, 34 and 58 cleared; all other bits pass through.
- R10: trapTaken is high for exactly the one cycle after the edge that takes a trap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| execReq | input | 1 | Execute the presented instruction on this edge |
| curPc | input | 64 | Address of the instruction being executed |
| msrIn | input | 64 | Current machine state register |
| privOp | input | 1 | Instruction requires supervisor state |
| illegalOp | input | 1 | Instruction encoding is illegal |
| nextPc | output | 64 | Registered next instruction address |
| msrOut | output | 64 | Registered updated MSR |
| srr0 | output | 64 | Saved address of the faulting instruction |
| srr1 | output | 64 | Saved old MSR with cause bit |
| trapTaken | output | 1 | One-cycle pulse after a trap is taken |

## Verification
Every cycle, the assertions check four things:
- only one cause is ever raised;
- a trap strobe always follows an execute and comes with the vector address and a saved address equal to the prior curPc;
- the forced MSR bits hold whenever a trap is taken;
- registered state holds across idle cycles.

The exact bit-by-bit MSR and saved-MSR images need scenarios in the bench, because they depend on the input MSR pattern. So do the priority between the two causes, the fact that a supervisor-only instruction runs normally in supervisor state, and the preservation of srr0 and srr1 across normal instructions.

// File: rtl/pgm_int_pkg.sv
package pgm_int_pkg;
  localparam int XLEN = 64;

  // Bit positions, LSB-0 numbering.
  localparam int BIT_LE   = 0;
  localparam int BIT_RI   = 1;
  localparam int BIT_PMM  = 2;
  localparam int BIT_DR   = 4;
  localparam int BIT_IR   = 5;
  localparam int BIT_FE1  = 8;
  localparam int BIT_FE0  = 11;
  localparam int BIT_FP   = 13;
  localparam int BIT_PR   = 14;
  localparam int BIT_EE   = 15;
  localparam int BIT_VSX  = 23;
  localparam int BIT_VEC  = 25;
  localparam int BIT_TM   = 32;
  localparam int BIT_TSE  = 33;
  localparam int BIT_TSS  = 34;
  localparam int BIT_UND  = 58;
  localparam int BIT_SF   = 63;

  localparam int CAUSE_PRIV_BIT = 18;
  localparam int CAUSE_ILL_BIT  = 19;

  localparam int NUM_CLR = 15;
  localparam int CLR_POS [NUM_CLR] = '{BIT_RI, BIT_PMM, BIT_DR, BIT_IR, BIT_FE1,
                                       BIT_FE0, BIT_FP, BIT_PR, BIT_EE, BIT_VSX,
                                       BIT_VEC, BIT_TM, BIT_TSE, BIT_TSS, BIT_UND};

  typedef struct packed {
    logic loadSeq;
    logic loadTrap;
    logic causePriv;
    logic causeIllegal;
  } ctlStrobes_t;

  function automatic logic [XLEN-1:0] entryClearMask();
    logic [XLEN-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_CLR; i++) m[CLR_POS[i]] = 1'b1;
    return m;
  endfunction

  function automatic logic [XLEN-1:0] entrySetMask();
    logic [XLEN-1:0] m;
    m = '0;
    m[BIT_SF] = 1'b1;
    m[BIT_LE] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pgm_int_ctrl.sv
module pgm_int_ctrl
  import pgm_int_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        execReq,
  input  logic        privOp,
  input  logic        illegalOp,
  input  logic        msrPr,
  output ctlStrobes_t strb
);
  logic privFault;
  logic illFault;

  always_comb begin
    privFault = privOp && msrPr;
    illFault  = illegalOp && !privFault;
    strb.causePriv    = execReq && privFault;
    strb.causeIllegal = execReq && illFault;
    strb.loadTrap     = strb.causePriv || strb.causeIllegal;
    strb.loadSeq      = execReq && !strb.loadTrap;
  end

  // R7
  cause_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.causePriv, strb.causeIllegal}));

  // R5
  sup_priv_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
    (execReq && privOp && !msrPr && !illegalOp) |-> strb.loadSeq);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !execReq |-> !(strb.loadSeq || strb.loadTrap));
endmodule

// File: rtl/pgm_int_dpath.sv
module pgm_int_dpath
  import pgm_int_pkg::*;
#(
  parameter logic [XLEN-1:0] VECTOR_ADDR = 64'h700,
  parameter logic [XLEN-1:0] PC_STEP     = 64'd4
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobes_t     strb,
  input  logic [XLEN-1:0] curPc,
  input  logic [XLEN-1:0] msrIn,
  output logic [XLEN-1:0] nextPc,
  output logic [XLEN-1:0] msrOut,
  output logic [XLEN-1:0] srr0,
  output logic [XLEN-1:0] srr1,
  output logic            trapTaken
);
  localparam logic [XLEN-1:0] CLR_MASK = entryClearMask();
  localparam logic [XLEN-1:0] SET_MASK = entrySetMask();

  logic [XLEN-1:0] causeVec;
  logic [XLEN-1:0] forcedMsr;

  always_comb begin
    causeVec = '0;
    causeVec[CAUSE_PRIV_BIT] = strb.causePriv;
    causeVec[CAUSE_ILL_BIT]  = strb.causeIllegal;
    forcedMsr = (msrIn & ~CLR_MASK) | SET_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextPc    <= '0;
      msrOut    <= '0;
      srr0      <= '0;
      srr1      <= '0;
      trapTaken <= 1'b0;
    end else begin
      trapTaken <= strb.loadTrap;
      if (strb.loadTrap) begin
        nextPc <= VECTOR_ADDR;
        msrOut <= forcedMsr;
        srr0   <= curPc;
        srr1   <= msrIn | causeVec;
      end else if (strb.loadSeq) begin
        nextPc <= curPc + PC_STEP;
        msrOut <= msrIn;
      end
    end
  end

  // R8
  trap_vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapTaken |-> (nextPc == VECTOR_ADDR));

  // R8
  trap_srr0_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadTrap |=> (srr0 == $past(curPc)));

  // R9
  trap_msr_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapTaken |-> (msrOut[BIT_SF] && msrOut[BIT_LE] && !msrOut[BIT_PR] && !msrOut[BIT_EE]));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.loadTrap || strb.loadSeq) |=> ($stable(nextPc) && $stable(msrOut) && $stable(srr0) && $stable(srr1)));

  // R3
  seq_srr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadSeq |=> ($stable(srr0) && $stable(srr1) && !trapTaken));
endmodule

// File: rtl/pgm_int_entry.sv
module pgm_int_entry
  import pgm_int_pkg::*;
#(
  parameter logic [XLEN-1:0] VECTOR_ADDR = 64'h700,
  parameter logic [XLEN-1:0] PC_STEP     = 64'd4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            execReq,
  input  logic [XLEN-1:0] curPc,
  input  logic [XLEN-1:0] msrIn,
  input  logic            privOp,
  input  logic            illegalOp,
  output logic [XLEN-1:0] nextPc,
  output logic [XLEN-1:0] msrOut,
  output logic [XLEN-1:0] srr0,
  output logic [XLEN-1:0] srr1,
  output logic            trapTaken
);
  ctlStrobes_t strb;

  pgm_int_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .execReq(execReq), .privOp(privOp),
    .illegalOp(illegalOp), .msrPr(msrIn[BIT_PR]), .strb(strb)
  );

  pgm_int_dpath #(.VECTOR_ADDR(VECTOR_ADDR), .PC_STEP(PC_STEP)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .curPc(curPc), .msrIn(msrIn),
    .nextPc(nextPc), .msrOut(msrOut), .srr0(srr0), .srr1(srr1),
    .trapTaken(trapTaken)
  );

  // R10
  trap_follows_exec_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapTaken |-> $past(execReq));
endmodule

// File: tb/pgm_int_entry_tb.sv
module pgm_int_entry_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic execReq = 1'b0;
  logic [63:0] curPc = '0;
  logic [63:0] msrIn = '0;
  logic privOp = 1'b0;
  logic illegalOp = 1'b0;
  logic [63:0] nextPc, msrOut, srr0, srr1;
  logic trapTaken;

  always #5 clk = ~clk;

  pgm_int_entry dut_i (
    .clk(clk), .rstN(rstN), .execReq(execReq), .curPc(curPc), .msrIn(msrIn),
    .privOp(privOp), .illegalOp(illegalOp), .nextPc(nextPc), .msrOut(msrOut),
    .srr0(srr0), .srr1(srr1), .trapTaken(trapTaken)
  );

  int nChecks = 0;
  int nFails = 0;

  // Bench-side masks from R9 and cause bits from R4/R6.
  localparam logic [63:0] TB_CLR = 64'h0400_0007_0280_E936;
  localparam logic [63:0] TB_SET = 64'h8000_0000_0000_0001;
  localparam logic [63:0] TB_PRIV = 64'h0000_0000_0004_0000;
  localparam logic [63:0] TB_ILL  = 64'h0000_0000_0008_0000;

  typedef struct packed {
    logic priv;
    logic ill;
    logic [63:0] pc;
    logic [63:0] msr;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 64'h0000_0000_0000_1000, 64'h8000_0000_0000_0001},
    '{1'b1, 1'b0, 64'h0000_0000_0000_1004, 64'h0000_0000_0000_4000},
    '{1'b1, 1'b0, 64'h0000_0000_0000_2000, 64'h0000_0000_0000_0000},
    '{1'b0, 1'b1, 64'h0000_0000_0000_3000, 64'hFFFF_FFFF_FFF3_BFFF},
    '{1'b1, 1'b1, 64'h0000_0000_0000_4000, 64'h0000_0000_0000_4000},
    '{1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFC, 64'h1234_5678_9ABC_DEF0},
    '{1'b1, 1'b0, 64'h0000_0000_0000_5000, 64'hFFFF_FFFF_FFFF_FFFF},
    '{1'b0, 1'b1, 64'h0000_0000_0000_6000, 64'h0000_0000_0000_0000}
  };

  task automatic check64(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doExec(input logic p, input logic il, input logic [63:0] pc,
                        input logic [63:0] m);
    @(negedge clk);
    execReq = 1'b1; privOp = p; illegalOp = il; curPc = pc; msrIn = m;
    @(negedge clk);
    execReq = 1'b0; privOp = 1'b0; illegalOp = 1'b0;
  endtask

  logic [63:0] eSrr0, eSrr1, eNext, eMsr;
  logic [63:0] hPc, hMsr, hS0, hS1;

  initial begin
    fork
      begin
        #1500000;
        nFails++;
        nChecks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    check64("R1", "nextPc in reset", nextPc, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    check64("R1", "msrOut", msrOut, 64'h0);
    check64("R1", "srr0", srr0, 64'h0);
    check64("R1", "srr1", srr1, 64'h0);
    check64("R1", "trapTaken", {63'h0, trapTaken}, 64'h0);

    eSrr0 = '0; eSrr1 = '0;
    for (int i = 0; i < NV; i++) begin
      logic trap, pf;
      pf   = VECS[i].priv && VECS[i].msr[14];
      trap = pf || VECS[i].ill;
      doExec(VECS[i].priv, VECS[i].ill, VECS[i].pc, VECS[i].msr);
      if (trap) begin
        eNext = 64'h700;
        eMsr  = (VECS[i].msr & ~TB_CLR) | TB_SET;
        eSrr0 = VECS[i].pc;
        eSrr1 = VECS[i].msr | (pf ? TB_PRIV : TB_ILL);
      end else begin
        eNext = VECS[i].pc + 64'd4;
        eMsr  = VECS[i].msr;
      end
      check64(trap ? "R8" : "R3", "nextPc", nextPc, eNext);
      check64(trap ? "R9" : "R3", "msrOut", msrOut, eMsr);
      check64(trap ? "R8" : "R3", "srr0", srr0, eSrr0);
      check64(pf ? "R4" : (VECS[i].ill ? "R6" : "R5"), "srr1", srr1, eSrr1);
      check64("R10", "trapTaken", {63'h0, trapTaken}, {63'h0, trap});
    end

    // R7: both causes, old MSR bit 19 clear -> only bit 18 recorded
    doExec(1'b1, 1'b1, 64'h7000, 64'h0000_0000_0000_4000);
    check64("R7", "srr1 priority", srr1, 64'h0000_0000_0004_4000);

    // R10: strobe drops on the next idle cycle; R2: state holds
    hPc = nextPc; hMsr = msrOut; hS0 = srr0; hS1 = srr1;
    @(negedge clk);
    check64("R10", "trapTaken drop", {63'h0, trapTaken}, 64'h0);
    privOp = 1'b1; illegalOp = 1'b1; msrIn = '1; curPc = 64'hABC0;
    repeat (2) @(negedge clk);
    check64("R2", "nextPc hold", nextPc, hPc);
    check64("R2", "msrOut hold", msrOut, hMsr);
    check64("R2", "srr0 hold", srr0, hS0);
    check64("R2", "srr1 hold", srr1, hS1);
    check64("R2", "no trap when idle", {63'h0, trapTaken}, 64'h0);

    // R8: cause bit absent from msrOut when not in old MSR
    doExec(1'b0, 1'b1, 64'h8000, 64'h0);
    check64("R8", "cause bit not in msrOut", msrOut & (TB_PRIV | TB_ILL), 64'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule